// File: doc/BRIEF.md
# Character Glyph Fetch Address Generator

A text-mode video controller reads glyph bitmaps from display memory one byte per scan line of each character cell. This block forms the 16-bit memory address of that byte. It joins the upper bits of a character-set base register, bit 7 of the cell's attribute byte, the 8-bit character code and the row-relative scan line number.

The scan line number comes from an internal counter. The counter clears at frame start and at each character row start. It advances on every end-of-line pulse and returns to 0 after it reaches the character vertical total. The vertical total is captured at frame start. That captured value selects one of two layouts. A total below 16 selects a short layout with a 4-bit scan field, 16 bytes per glyph and 8K character-set steps. A total of 16 or more selects a tall layout with a 5-bit scan field, 32 bytes per glyph and 16K steps.

A fetch request made while display enable is high produces a registered address one clock later, together with a one-clock valid strobe.

Top module: `glyph_addr_gen`

## Requirements
- R1: In short mode (captured total < 16), addr_o = {cset_base_i[7:5], attr bit, char_code_i[7:0], scan[3:0]}, where attr bit is attr_i[7] gated by attr_en_i.
- R2: In tall mode (captured total >= 16), addr_o = {cset_base_i[7:6], attr bit, char_code_i[7:0], scan[4:0]}.
- R3: When attr_en_i is 0, the attribute position (bit 12 in short mode, bit 13 in tall mode) is 0 whatever attr_i holds.
- R4: cset_base_i bits 4..0, and bit 5 in tall mode, have no effect on addr_o.
- R5: The scan counter is 0 in the cycle after frame_start_i or row_start_i. Either start pulse takes priority over line_end_i.
- R6: Each line_end_i cycle advances the scan counter by 1. When the counter equals the captured total, the next line_end_i returns it to 0.
- R7: vtotal_i is captured only on frame_start_i. Changing vtotal_i at any other time changes neither the layout nor the wrap point.
- R8: addr_vld_o is high for exactly the one cycle after each cycle with fetch_req_i and disp_en_i both high, and low otherwise. addr_o updates only with addr_vld_o and holds its value between fetches.
- R9: After reset, addr_o is 0, addr_vld_o is 0, the scan counter is 0 and the layout is short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame start pulse; captures vertical total, clears counter |
| row_start_i | input | 1 | Character row start pulse; clears counter |
| line_end_i | input | 1 | End-of-raster-line pulse; advances counter |
| disp_en_i | input | 1 | Visible region flag |
| fetch_req_i | input | 1 | Cell fetch request |
| vtotal_i | input | 5 | Character vertical total register |
| cset_base_i | input | 8 | Character-set base register |
| attr_en_i | input | 1 | Attribute enable |
| attr_i | input | 8 | Cell attribute byte |
| char_code_i | input | 8 | Character code |
| addr_o | output | 16 | Glyph byte address |
| addr_vld_o | output | 1 | Address valid strobe |

## Verification
A wrong scan counter value appears in the low field of the next fetched address. In tall mode it can also appear in bit 4. Each vector therefore drives a known number of line pulses before a single fetch and compares the full 16 bits one clock after the request. A wrongly captured layout shifts the code field by one bit, so every nonzero code shows the fault on the first fetch after the frame start. A late or missing capture appears when the vertical total changes in mid-frame and the result is checked against the old layout.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned BASE_W = 8;
  localparam int unsigned SHORT_SCAN_W = 4;
  localparam int unsigned TALL_SCAN_W  = 5;

  typedef enum logic {
    LAYOUT_SHORT = 1'b0,
    LAYOUT_TALL  = 1'b1
  } layout_e;
endpackage

// File: rtl/glyph_mode_latch.sv
module glyph_mode_latch #(
  parameter int unsigned VT_W        = 5,
  parameter int unsigned TALL_THRESH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic [VT_W-1:0]      vtotal_i,
  output logic [VT_W-1:0]      vt_o,
  output glyph_pkg::layout_e   layout_o
);
  import glyph_pkg::*;

  logic [VT_W-1:0] vt_q;
  layout_e         layout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vt_q     <= '0;
      layout_q <= LAYOUT_SHORT;
    end else if (frame_start_i) begin
      vt_q     <= vtotal_i;
      layout_q <= (32'(vtotal_i) >= TALL_THRESH) ? LAYOUT_TALL : LAYOUT_SHORT;
    end
  end

  assign vt_o     = vt_q;
  assign layout_o = layout_q;

  assert_layout_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(layout_q) && $stable(vt_q)));
endmodule

// File: rtl/glyph_scan_ctr.sv
module glyph_scan_ctr #(
  parameter int unsigned VT_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic            row_start_i,
  input  logic            line_end_i,
  input  logic [VT_W-1:0] vt_i,
  output logic [VT_W-1:0] scan_o
);
  logic [VT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (frame_start_i || row_start_i) cnt_q <= '0;
    else if (line_end_i)                  cnt_q <= (cnt_q == vt_i) ? '0 : cnt_q + 1'b1;
  end

  assign scan_o = cnt_q;

  assert_ctr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i || row_start_i) |=> (cnt_q == '0));
  assert_ctr_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && !frame_start_i && !row_start_i && cnt_q == vt_i) |=> (cnt_q == '0));
  assert_ctr_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= vt_i);
endmodule

// File: rtl/glyph_addr_pack.sv
module glyph_addr_pack
  import glyph_pkg::*;
(
  input  layout_e                   layout_i,
  input  logic [BASE_W-1:0]         base_i,
  input  logic                      attr_bit_i,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [TALL_SCAN_W-1:0]    scan_i,
  output logic [ADDR_W-1:0]         addr_o
);
  logic unused_base;
  assign unused_base = ^base_i[BASE_W-4:0];

  always_comb begin
    if (layout_i == LAYOUT_TALL)
      addr_o = {base_i[BASE_W-1 -: 2], attr_bit_i, code_i, scan_i[TALL_SCAN_W-1:0]};
    else
      addr_o = {base_i[BASE_W-1 -: 3], attr_bit_i, code_i, scan_i[SHORT_SCAN_W-1:0]};
  end
endmodule

// File: rtl/glyph_addr_gen.sv
module glyph_addr_gen
  import glyph_pkg::*;
#(
  parameter int unsigned VT_W        = 5,
  parameter int unsigned TALL_THRESH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 row_start_i,
  input  logic                 line_end_i,
  input  logic                 disp_en_i,
  input  logic                 fetch_req_i,
  input  logic [VT_W-1:0]      vtotal_i,
  input  logic [BASE_W-1:0]    cset_base_i,
  input  logic                 attr_en_i,
  input  logic [7:0]           attr_i,
  input  logic [CODE_W-1:0]    char_code_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 addr_vld_o
);
  logic [VT_W-1:0]    vt;
  layout_e            layout;
  logic [VT_W-1:0]    scan;
  logic [ADDR_W-1:0]  addr_d;
  logic [ADDR_W-1:0]  addr_q;
  logic               vld_q;
  logic               take;
  logic               unused_attr;

  assign unused_attr = ^attr_i[6:0];
  assign take = fetch_req_i && disp_en_i;

  glyph_mode_latch #(.VT_W(VT_W), .TALL_THRESH(TALL_THRESH)) u_mode (
    .clk_i, .rst_ni, .frame_start_i, .vtotal_i,
    .vt_o(vt), .layout_o(layout)
  );

  glyph_scan_ctr #(.VT_W(VT_W)) u_ctr (
    .clk_i, .rst_ni, .frame_start_i, .row_start_i, .line_end_i,
    .vt_i(vt), .scan_o(scan)
  );

  glyph_addr_pack u_pack (
    .layout_i(layout), .base_i(cset_base_i),
    .attr_bit_i(attr_en_i & attr_i[7]), .code_i(char_code_i),
    .scan_i(scan[TALL_SCAN_W-1:0]), .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) addr_q <= addr_d;
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;

  assert_vld_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> $past(fetch_req_i && disp_en_i));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(addr_o));
  assert_attr_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !attr_en_i) |=>
      ((layout == LAYOUT_TALL) ? (addr_o[13] == 1'b0) : (addr_o[12] == 1'b0)));
endmodule

// File: tb/sim_glyph_addr_gen.sv
module sim_glyph_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, row_start = 0, line_end = 0, disp_en = 0, fetch_req = 0;
  logic [4:0]  vtotal = '0;
  logic [7:0]  base = '0, attr = '0, code = '0;
  logic        attr_en = 0;
  logic [15:0] addr;
  logic        vld;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  glyph_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .row_start_i(row_start),
    .line_end_i(line_end), .disp_en_i(disp_en), .fetch_req_i(fetch_req),
    .vtotal_i(vtotal), .cset_base_i(base), .attr_en_i(attr_en), .attr_i(attr),
    .char_code_i(code), .addr_o(addr), .addr_vld_o(vld)
  );

  typedef struct packed {
    logic [4:0]  vt;
    logic [7:0]  base;
    logic        en;
    logic [7:0]  attr;
    logic [7:0]  code;
    logic [5:0]  lines;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd7,  8'hE0, 1'b1, 8'h80, 8'h41, 6'd3,  16'hF413},
    '{5'd7,  8'h1F, 1'b1, 8'h7F, 8'hFF, 6'd7,  16'h0FF7},
    '{5'd7,  8'hA0, 1'b0, 8'h80, 8'h12, 6'd8,  16'hA120},
    '{5'd15, 8'h40, 1'b1, 8'h80, 8'h00, 6'd15, 16'h500F},
    '{5'd16, 8'hC0, 1'b1, 8'h80, 8'h41, 6'd16, 16'hE830},
    '{5'd31, 8'h20, 1'b1, 8'h80, 8'hFF, 6'd31, 16'h3FFF},
    '{5'd20, 8'h7F, 1'b0, 8'hFF, 8'h80, 6'd21, 16'h5000},
    '{5'd0,  8'h00, 1'b1, 8'h80, 8'h01, 6'd2,  16'h1010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic new_frame(input logic [4:0] vt);
    @(negedge clk); vtotal = vt; frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic pulse_lines(input int n);
    if (n > 0) begin
      @(negedge clk); line_end = 1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); line_end = 0;
    end
  endtask

  task automatic pulse_row;
    @(negedge clk); row_start = 1;
    @(negedge clk); row_start = 0;
  endtask

  // Request in one cycle; address and strobe are visible one clock later.
  task automatic fetch(input string req, input logic [15:0] exp);
    @(negedge clk); fetch_req = 1; disp_en = 1;
    @(negedge clk); fetch_req = 0;
    check({req, " strobe"}, 32'(vld), 32'd1);
    check({req, " addr"}, 32'(addr), 32'(exp));
    @(negedge clk);
    check("R8 strobe one clock", 32'(vld), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset addr", 32'(addr), 32'd0);
    check("R9 reset strobe", 32'(vld), 32'd0);
    rst_n = 1;
    // Reset layout is short with total 0: counter stays at 0.
    @(negedge clk); attr_en = 1; attr = 8'h80; code = 8'h23; base = 8'h60;
    pulse_lines(3);
    fetch("R9 reset short layout", 16'h7230);

    for (int i = 0; i < NV; i++) begin
      base = VECS[i].base; attr_en = VECS[i].en; attr = VECS[i].attr; code = VECS[i].code;
      new_frame(VECS[i].vt);
      pulse_lines(int'(VECS[i].lines));
      fetch((VECS[i].vt >= 5'd16) ? "R2 R3 R4 R6 layout" : "R1 R3 R4 R6 layout",
            VECS[i].exp);
    end

    // R7: total change without frame start keeps short layout and wrap at 7.
    base = 8'hE0; attr_en = 1; attr = 8'h80; code = 8'h41;
    new_frame(5'd7);
    pulse_lines(3);
    @(negedge clk); vtotal = 5'd20;
    fetch("R7 mid-frame total ignored", 16'hF413);
    pulse_lines(5);
    fetch("R7 wrap uses captured total", 16'hF410);
    new_frame(5'd20);
    pulse_lines(3);
    fetch("R7 new total at frame start", 16'hE823);

    // R5: row start clears the counter, and wins over a coincident line pulse.
    base = 8'h00; attr_en = 0; attr = 8'hFF; code = 8'h00;
    new_frame(5'd15);
    pulse_lines(5);
    pulse_row();
    fetch("R5 row start clears", 16'h0000);
    pulse_lines(1);
    fetch("R5 count after row start", 16'h0001);
    @(negedge clk); row_start = 1; line_end = 1;
    @(negedge clk); row_start = 0; line_end = 0;
    fetch("R5 row start over line end", 16'h0000);

    // R8: no strobe or address change without both request and enable.
    held = addr;
    code = 8'hAA;
    @(negedge clk); fetch_req = 1; disp_en = 0;
    @(negedge clk); fetch_req = 0;
    check("R8 no strobe when display off", 32'(vld), 32'd0);
    check("R8 addr held when display off", 32'(addr), 32'(held));
    @(negedge clk); disp_en = 1;
    @(negedge clk);
    check("R8 no strobe without request", 32'(vld), 32'd0);
    check("R8 addr held without request", 32'(addr), 32'(held));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule